// File: doc/BRIEF.md
# Link Control and Latched Status Register Bank

This block is the software-visible register file of a multi-lane serial link core. A register port with a valid strobe, a write flag, a 12-bit byte address and 32-bit write data reaches it every cycle. It holds the link's configuration as plain read/write fields and drives them out as levels: per-lane and per-path resets, transmit enable and framing-control bits, diagnostic-word fields, a receive resync request and a loopback select. A write of one to a command bit produces a single-cycle pulse, and that bit never reads back as set.

Event and condition inputs from the datapath are captured so that software cannot miss a short excursion. Error events latch high until a read of their register. Health conditions (alignment, per-lane word sync, per-lane sync) latch low until a read. A read re-arms the captured bits, and an event present in the read cycle itself stays captured. Free-running statistics counters enter as one flat bus. A tick command copies all of them at once into holding registers, which software can then read one after another without seeing a torn set.

Top module: `lnk_csr_bank`

## Requirements
- R1: A read of offset 0x000 returns 0x0000_0205: minor number 5 in bits 7:0, major number 2 in bits 15:8, zero above. Writes leave it unchanged.
- R2: A read request is answered one clock later with `rd_vld_o` high for one cycle and the word on `rd_data_o`.
- R3: Writing 1 to bit 0 of offset 0x004 raises `xcvr_rst_o` for exactly the one cycle after the write. Writing 0 gives no pulse, and the offset reads 0.
- R4: Offset 0x008 is read/write with default 0: per-lane receive resets in bits 11:0, transmit reference-clock path reset in bit 12, receive path reset in bit 30, transmit path reset in bit 31. Each field drives its output, and the other bits read 0.
- R5: Configuration fields are read/write, default 0, and drive their outputs. At 0x00C, bit 0 is transmit enable and bits 8:1 are the transmit framing bits. At 0x010, bit 0 is interface status and bits 12:1 are lane status for the transmitted diagnostic word. At 0x014, bit 0 requests a receive resync. At 0x018, bit 0 selects loopback (0 normal, 1 near-end). Unlisted bits read 0.
- R6: Latch-high error fields: 0x200 bits 2:0 from `tx_err_i`, 0x204 bits 5:1 from `rx_err_i`, 0x224 bits 11:0 from `frame_err_i`, 0x228 bits 11:0 from `descr_err_i`. A one-cycle high input makes its bit read 1 until that register is read.
- R7: Latch-low condition fields: 0x204 bit 0 from `rx_aligned_i`, 0x204 bits 19:8 from `word_sync_i`, 0x210 bits 11:0 from `synced_i`. A one-cycle low input makes its bit read 0 until that register is read.
- R8: After reset, latch-low fields read all ones (0x204 reads 0x000F_FF01, 0x210 reads 0xFFF) and latch-high fields read 0.
- R9: Reading a latched register re-arms it, so it next shows the input as sampled in the read cycle. An event present in the read cycle itself stays latched.
- R10: Writing 1 to bit 0 of offset 0x2B0 copies every counter lane of `cnt_i` in that same cycle into its holding register, readable at 0x300 + 4*i. Offset 0x2B0 reads 0.
- R11: Holding registers keep their snapshot until the next tick, whatever the counters do meanwhile.
- R12: Reads of unmapped or unaligned offsets return 0. Writes to read-only or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | Access request strobe |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| xcvr_rst_o | output | 1 | Transceiver reset command pulse |
| lane_rx_rst_o | output | 12 | Per-lane receive reset |
| tx_refclk_rst_o | output | 1 | Transmit reference-clock path reset |
| rx_path_rst_o | output | 1 | Receive path reset |
| tx_path_rst_o | output | 1 | Transmit path reset |
| tx_en_o | output | 1 | Transmit enable |
| tx_mubits_o | output | 8 | Transmit framing-control bits |
| tx_diag_intf_o | output | 1 | Diagnostic word interface status |
| tx_diag_lane_o | output | 12 | Diagnostic word lane status |
| rx_resync_o | output | 1 | Receive resync request |
| loopback_o | output | 1 | Near-end loopback select |
| tx_err_i | input | 3 | Transmit error events |
| rx_err_i | input | 5 | Receive link-wide error events |
| rx_aligned_i | input | 1 | Receive alignment condition |
| word_sync_i | input | 12 | Per-lane word sync condition |
| synced_i | input | 12 | Per-lane sync condition |
| frame_err_i | input | 12 | Per-lane framing error events |
| descr_err_i | input | 12 | Per-lane descrambler error events |
| cnt_i | input | 128 | Four 32-bit free-running counters, lane i in bits 32*i+31:32*i |

## Verification
Control outputs, captured status bits and holding registers all change at the edge that takes the request or the input, so the bench drives at a falling edge and samples at the next falling edge. The transceiver reset pulse is therefore checked high at the first falling edge after the write edge and low at the next one. Read data is registered, so each read is sampled half a cycle after its request edge together with `rd_vld_o`. Event and condition stimuli are held across exactly one rising edge, or across the read edge itself for the read-cycle case, so each expected value follows from which edges saw the input.

// File: rtl/lnk_csr_pkg.sv
package lnk_csr_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_VERSION = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_XRST    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RESET   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_TXCFG   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_TXDIAG  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RXCFG   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_LOOP    = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_TXSTAT  = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_RXSTAT  = 12'h204;
  localparam logic [ADDR_W-1:0] OFS_SYNCED  = 12'h210;
  localparam logic [ADDR_W-1:0] OFS_FRMERR  = 12'h224;
  localparam logic [ADDR_W-1:0] OFS_DSCERR  = 12'h228;
  localparam logic [ADDR_W-1:0] OFS_TICK    = 12'h2B0;
  localparam logic [3:0]        CNT_PAGE    = 4'h3;

  typedef struct packed {
    logic              wr_stb;
    logic              rd_stb;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } csr_acc_t;
endpackage

// File: rtl/lnk_csr_sticky.sv
module lnk_csr_sticky #(
  parameter int WIDTH     = 1,
  parameter bit LATCH_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] lat_o
);
  localparam logic [WIDTH-1:0] RST_VAL = LATCH_LOW ? '1 : '0;

  logic [WIDTH-1:0] lat_q, lat_d;

  generate
    if (LATCH_LOW) begin : g_low
      always_comb lat_d = clr_i ? sig_i : (lat_q & sig_i);

      // R7
      loss_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (~sig_i != '0) |=> ((lat_q & $past(~sig_i)) == '0));
      // R9
      low_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((lat_q | $past(lat_q)) == $past(lat_q)));
    end else begin : g_high
      always_comb lat_d = clr_i ? sig_i : (lat_q | sig_i);

      // R6
      event_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sig_i != '0) |=> ((lat_q & $past(sig_i)) == $past(sig_i)));
      // R9
      high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((lat_q & $past(lat_q)) == $past(lat_q)));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= RST_VAL;
    else         lat_q <= lat_d;
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/lnk_csr_snap.sv
module lnk_csr_snap #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_i,
  output logic [NUM_CNT*CNT_W-1:0] hold_o
);
  logic [NUM_CNT*CNT_W-1:0] hold_q;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hold_q[i*CNT_W +: CNT_W] <= '0;
      else if (tick_i) hold_q[i*CNT_W +: CNT_W] <= cnt_i[i*CNT_W +: CNT_W];
    end
  end

  // R10
  snap_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (hold_q == $past(cnt_i)));
  // R11
  snap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(hold_q));

  assign hold_o = hold_q;
endmodule

// File: rtl/lnk_csr_ctrl.sv
module lnk_csr_ctrl
  import lnk_csr_pkg::*;
#(
  parameter int NUM_LANES = 12,
  parameter int MU_W      = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  csr_acc_t             acc_i,
  output logic                 xcvr_rst_o,
  output logic [NUM_LANES-1:0] lane_rx_rst_o,
  output logic                 tx_refclk_rst_o,
  output logic                 rx_path_rst_o,
  output logic                 tx_path_rst_o,
  output logic                 tx_en_o,
  output logic [MU_W-1:0]      tx_mubits_o,
  output logic                 tx_diag_intf_o,
  output logic [NUM_LANES-1:0] tx_diag_lane_o,
  output logic                 rx_resync_o,
  output logic                 loopback_o
);
  logic wr_reset, wr_txcfg, wr_txdiag, wr_rxcfg, wr_loop, xrst_cmd;

  assign wr_reset  = acc_i.wr_stb && (acc_i.addr == OFS_RESET);
  assign wr_txcfg  = acc_i.wr_stb && (acc_i.addr == OFS_TXCFG);
  assign wr_txdiag = acc_i.wr_stb && (acc_i.addr == OFS_TXDIAG);
  assign wr_rxcfg  = acc_i.wr_stb && (acc_i.addr == OFS_RXCFG);
  assign wr_loop   = acc_i.wr_stb && (acc_i.addr == OFS_LOOP);
  assign xrst_cmd  = acc_i.wr_stb && (acc_i.addr == OFS_XRST) && acc_i.wdata[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xcvr_rst_o      <= 1'b0;
      lane_rx_rst_o   <= '0;
      tx_refclk_rst_o <= 1'b0;
      rx_path_rst_o   <= 1'b0;
      tx_path_rst_o   <= 1'b0;
      tx_en_o         <= 1'b0;
      tx_mubits_o     <= '0;
      tx_diag_intf_o  <= 1'b0;
      tx_diag_lane_o  <= '0;
      rx_resync_o     <= 1'b0;
      loopback_o      <= 1'b0;
    end else begin
      xcvr_rst_o <= xrst_cmd;  // self-clearing
      if (wr_reset) begin
        lane_rx_rst_o   <= acc_i.wdata[NUM_LANES-1:0];
        tx_refclk_rst_o <= acc_i.wdata[12];
        rx_path_rst_o   <= acc_i.wdata[30];
        tx_path_rst_o   <= acc_i.wdata[31];
      end
      if (wr_txcfg) begin
        tx_en_o     <= acc_i.wdata[0];
        tx_mubits_o <= acc_i.wdata[MU_W:1];
      end
      if (wr_txdiag) begin
        tx_diag_intf_o <= acc_i.wdata[0];
        tx_diag_lane_o <= acc_i.wdata[NUM_LANES:1];
      end
      if (wr_rxcfg) rx_resync_o <= acc_i.wdata[0];
      if (wr_loop)  loopback_o  <= acc_i.wdata[0];
    end
  end

  // R3
  xrst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcvr_rst_o |=> !xcvr_rst_o);
  // R3
  xrst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i.wr_stb && acc_i.addr == OFS_XRST && acc_i.wdata[0]) |=> xcvr_rst_o);
  // R5
  loop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i.wr_stb && acc_i.addr == OFS_LOOP) |=> $stable(loopback_o));
endmodule

// File: rtl/lnk_csr_bank.sv
module lnk_csr_bank
  import lnk_csr_pkg::*;
#(
  parameter int          NUM_LANES = 12,
  parameter int          NUM_CNT   = 4,
  parameter int          CNT_W     = 32,
  parameter logic [7:0]  VER_MAJOR = 8'd2,
  parameter logic [7:0]  VER_MINOR = 8'd5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_vld_i,
  input  logic                     req_wr_i,
  input  logic [11:0]              req_addr_i,
  input  logic [31:0]              req_wdata_i,
  output logic                     rd_vld_o,
  output logic [31:0]              rd_data_o,
  output logic                     xcvr_rst_o,
  output logic [NUM_LANES-1:0]     lane_rx_rst_o,
  output logic                     tx_refclk_rst_o,
  output logic                     rx_path_rst_o,
  output logic                     tx_path_rst_o,
  output logic                     tx_en_o,
  output logic [7:0]               tx_mubits_o,
  output logic                     tx_diag_intf_o,
  output logic [NUM_LANES-1:0]     tx_diag_lane_o,
  output logic                     rx_resync_o,
  output logic                     loopback_o,
  input  logic [2:0]               tx_err_i,
  input  logic [4:0]               rx_err_i,
  input  logic                     rx_aligned_i,
  input  logic [NUM_LANES-1:0]     word_sync_i,
  input  logic [NUM_LANES-1:0]     synced_i,
  input  logic [NUM_LANES-1:0]     frame_err_i,
  input  logic [NUM_LANES-1:0]     descr_err_i,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_i
);
  localparam int TXE_W  = 3;
  localparam int RXE_W  = 5;
  localparam int IDX_W  = 6;
  localparam int SYNC_LSB = 8;

  csr_acc_t acc;
  assign acc.wr_stb = req_vld_i && req_wr_i;
  assign acc.rd_stb = req_vld_i && !req_wr_i;
  assign acc.addr   = req_addr_i;
  assign acc.wdata  = req_wdata_i;

  // control registers
  lnk_csr_ctrl #(.NUM_LANES(NUM_LANES), .MU_W(8)) u_ctrl (
    .clk_i, .rst_ni, .acc_i(acc),
    .xcvr_rst_o, .lane_rx_rst_o, .tx_refclk_rst_o, .rx_path_rst_o,
    .tx_path_rst_o, .tx_en_o, .tx_mubits_o, .tx_diag_intf_o,
    .tx_diag_lane_o, .rx_resync_o, .loopback_o
  );

  // read-to-clear strobes
  logic clr_txstat, clr_rxstat, clr_synced, clr_frm, clr_dsc;
  assign clr_txstat = acc.rd_stb && (req_addr_i == OFS_TXSTAT);
  assign clr_rxstat = acc.rd_stb && (req_addr_i == OFS_RXSTAT);
  assign clr_synced = acc.rd_stb && (req_addr_i == OFS_SYNCED);
  assign clr_frm    = acc.rd_stb && (req_addr_i == OFS_FRMERR);
  assign clr_dsc    = acc.rd_stb && (req_addr_i == OFS_DSCERR);

  logic [TXE_W-1:0]     txe_lat;
  logic [RXE_W-1:0]     rxe_lat;
  logic                 algn_lat;
  logic [NUM_LANES-1:0] wsync_lat, synced_lat, frm_lat, dsc_lat;

  lnk_csr_sticky #(.WIDTH(TXE_W), .LATCH_LOW(1'b0)) u_txe (
    .clk_i, .rst_ni, .sig_i(tx_err_i), .clr_i(clr_txstat), .lat_o(txe_lat));
  lnk_csr_sticky #(.WIDTH(RXE_W), .LATCH_LOW(1'b0)) u_rxe (
    .clk_i, .rst_ni, .sig_i(rx_err_i), .clr_i(clr_rxstat), .lat_o(rxe_lat));
  lnk_csr_sticky #(.WIDTH(1), .LATCH_LOW(1'b1)) u_algn (
    .clk_i, .rst_ni, .sig_i(rx_aligned_i), .clr_i(clr_rxstat), .lat_o(algn_lat));
  lnk_csr_sticky #(.WIDTH(NUM_LANES), .LATCH_LOW(1'b1)) u_wsync (
    .clk_i, .rst_ni, .sig_i(word_sync_i), .clr_i(clr_rxstat), .lat_o(wsync_lat));
  lnk_csr_sticky #(.WIDTH(NUM_LANES), .LATCH_LOW(1'b1)) u_synced (
    .clk_i, .rst_ni, .sig_i(synced_i), .clr_i(clr_synced), .lat_o(synced_lat));
  lnk_csr_sticky #(.WIDTH(NUM_LANES), .LATCH_LOW(1'b0)) u_frm (
    .clk_i, .rst_ni, .sig_i(frame_err_i), .clr_i(clr_frm), .lat_o(frm_lat));
  lnk_csr_sticky #(.WIDTH(NUM_LANES), .LATCH_LOW(1'b0)) u_dsc (
    .clk_i, .rst_ni, .sig_i(descr_err_i), .clr_i(clr_dsc), .lat_o(dsc_lat));

  // counter snapshot
  logic                     tick;
  logic [NUM_CNT*CNT_W-1:0] hold;
  assign tick = acc.wr_stb && (req_addr_i == OFS_TICK) && req_wdata_i[0];

  lnk_csr_snap #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_snap (
    .clk_i, .rst_ni, .tick_i(tick), .cnt_i, .hold_o(hold));

  // read mux
  logic [IDX_W-1:0] cnt_idx;
  logic             cnt_hit;
  logic [31:0]      rd_word;

  assign cnt_idx = req_addr_i[IDX_W+1:2];
  assign cnt_hit = (req_addr_i[11:8] == CNT_PAGE) && (req_addr_i[1:0] == 2'b00)
                && (int'(cnt_idx) < NUM_CNT);

  always_comb begin
    rd_word = '0;
    if (cnt_hit) begin
      for (int i = 0; i < NUM_CNT; i++)
        if (int'(cnt_idx) == i) rd_word[CNT_W-1:0] = hold[i*CNT_W +: CNT_W];
    end else begin
      unique case (req_addr_i)
        OFS_VERSION: rd_word[15:0] = {VER_MAJOR, VER_MINOR};
        OFS_RESET: begin
          rd_word[NUM_LANES-1:0] = lane_rx_rst_o;
          rd_word[12]            = tx_refclk_rst_o;
          rd_word[30]            = rx_path_rst_o;
          rd_word[31]            = tx_path_rst_o;
        end
        OFS_TXCFG:  rd_word[8:0] = {tx_mubits_o, tx_en_o};
        OFS_TXDIAG: begin
          rd_word[0]             = tx_diag_intf_o;
          rd_word[NUM_LANES:1]   = tx_diag_lane_o;
        end
        OFS_RXCFG:  rd_word[0] = rx_resync_o;
        OFS_LOOP:   rd_word[0] = loopback_o;
        OFS_TXSTAT: rd_word[TXE_W-1:0] = txe_lat;
        OFS_RXSTAT: begin
          rd_word[0]                      = algn_lat;
          rd_word[RXE_W:1]                = rxe_lat;
          rd_word[SYNC_LSB +: NUM_LANES]  = wsync_lat;
        end
        OFS_SYNCED: rd_word[NUM_LANES-1:0] = synced_lat;
        OFS_FRMERR: rd_word[NUM_LANES-1:0] = frm_lat;
        OFS_DSCERR: rd_word[NUM_LANES-1:0] = dsc_lat;
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o  <= acc.rd_stb;
      rd_data_o <= acc.rd_stb ? rd_word : '0;
    end
  end

  // R2
  rd_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc.rd_stb |=> rd_vld_o);
  // R2
  rd_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc.rd_stb |=> !rd_vld_o);
  // R12
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc.rd_stb && (req_addr_i[11:8] == 4'h1 || req_addr_i[11:8] == 4'hF)) |=> (rd_data_o == '0));
  // R1
  version_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc.rd_stb && req_addr_i == OFS_VERSION) |=> (rd_data_o == {16'h0, VER_MAJOR, VER_MINOR}));
endmodule

// File: tb/lnk_csr_bank_tb.sv
module lnk_csr_bank_tb_top;
  localparam int CLK_P     = 10;
  localparam int NUM_LANES = 12;
  localparam int NUM_CNT   = 4;
  localparam int CNT_W     = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        req_vld = 0, req_wr = 0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_vld;
  logic [31:0] rd_data;
  logic        xcvr_rst, tx_refclk_rst, rx_path_rst, tx_path_rst, tx_en;
  logic        tx_diag_intf, rx_resync, loopback;
  logic [NUM_LANES-1:0] lane_rx_rst, tx_diag_lane;
  logic [7:0]  tx_mubits;
  logic [2:0]  tx_err = '0;
  logic [4:0]  rx_err = '0;
  logic        rx_aligned = 1'b1;
  logic [NUM_LANES-1:0] word_sync = '1, synced = '1, frame_err = '0, descr_err = '0;
  logic [NUM_CNT*CNT_W-1:0] cnt_bus = '0;

  lnk_csr_bank #(.NUM_LANES(NUM_LANES), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_vld_i(req_vld), .req_wr_i(req_wr), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_vld_o(rd_vld), .rd_data_o(rd_data),
    .xcvr_rst_o(xcvr_rst), .lane_rx_rst_o(lane_rx_rst), .tx_refclk_rst_o(tx_refclk_rst),
    .rx_path_rst_o(rx_path_rst), .tx_path_rst_o(tx_path_rst), .tx_en_o(tx_en),
    .tx_mubits_o(tx_mubits), .tx_diag_intf_o(tx_diag_intf), .tx_diag_lane_o(tx_diag_lane),
    .rx_resync_o(rx_resync), .loopback_o(loopback),
    .tx_err_i(tx_err), .rx_err_i(rx_err), .rx_aligned_i(rx_aligned),
    .word_sync_i(word_sync), .synced_i(synced), .frame_err_i(frame_err),
    .descr_err_i(descr_err), .cnt_i(cnt_bus)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_vld = 1; req_wr = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_vld = 0; req_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_vld = 1; req_wr = 0; req_addr = a;
    @(negedge clk);
    req_vld = 0;
    chk("R2 rd_vld", {31'b0, rd_vld}, 32'h1);
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  function automatic logic [31:0] cval(input int i, input int r);
    return 32'h1000_0000 * (i + 1) + 32'h0001_0011 * r + i;
  endfunction

  localparam logic [31:0] RX_IDLE = 32'h000F_FF01;

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd_chk("R1 version", 12'h000, 32'h0000_0205);
    rd_chk("R4 reset default", 12'h008, 32'h0);
    rd_chk("R5 txcfg default", 12'h00C, 32'h0);
    rd_chk("R5 loop default", 12'h018, 32'h0);
    rd_chk("R8 txstat reset", 12'h200, 32'h0);
    rd_chk("R8 rxstat reset", 12'h204, RX_IDLE);
    rd_chk("R8 synced reset", 12'h210, 32'h0000_0FFF);
    rd_chk("R8 frmerr reset", 12'h224, 32'h0);
    rd_chk("R8 dscerr reset", 12'h228, 32'h0);
    chk("R8 outputs reset", {lane_rx_rst, tx_en, loopback, xcvr_rst}, '0);

    // R3 command pulse
    wr(12'h004, 32'h1);
    chk("R3 pulse high", {31'b0, xcvr_rst}, 32'h1);
    @(negedge clk);
    chk("R3 pulse low", {31'b0, xcvr_rst}, 32'h0);
    wr(12'h004, 32'h0);
    chk("R3 no pulse on 0", {31'b0, xcvr_rst}, 32'h0);
    rd_chk("R3 reads zero", 12'h004, 32'h0);

    // R4 walking bits over reset register
    for (int b = 0; b < 32; b++) begin
      logic [31:0] v;
      v = 32'h1 << b;
      wr(12'h008, v);
      chk("R4 outputs", {tx_path_rst, rx_path_rst, 17'b0, tx_refclk_rst, lane_rx_rst},
          v & 32'hC000_1FFF);
      rd_chk("R4 readback", 12'h008, v & 32'hC000_1FFF);
    end
    wr(12'h008, 32'hFFFF_FFFF);
    rd_chk("R4 all ones", 12'h008, 32'hC000_1FFF);

    // R5 walking bits over configuration registers
    for (int b = 0; b < 32; b++) begin
      logic [31:0] v;
      v = 32'h1 << b;
      wr(12'h00C, v);
      chk("R5 txcfg outputs", {23'b0, tx_mubits, tx_en}, v & 32'h1FF);
      rd_chk("R5 txcfg readback", 12'h00C, v & 32'h1FF);
      wr(12'h010, v);
      chk("R5 txdiag outputs", {19'b0, tx_diag_lane, tx_diag_intf}, v & 32'h1FFF);
      rd_chk("R5 txdiag readback", 12'h010, v & 32'h1FFF);
      wr(12'h014, v);
      chk("R5 resync output", {31'b0, rx_resync}, v & 32'h1);
      wr(12'h018, v);
      chk("R5 loopback output", {31'b0, loopback}, v & 32'h1);
      rd_chk("R5 loop readback", 12'h018, v & 32'h1);
    end

    // R6 latch-high, R9 re-arm
    for (int b = 0; b < 3; b++) begin
      @(negedge clk) tx_err = 3'b1 << b;
      @(negedge clk) tx_err = '0;
      rd_chk("R6 txstat latched", 12'h200, 32'h1 << b);
      rd_chk("R9 txstat rearmed", 12'h200, 32'h0);
    end
    for (int b = 0; b < 5; b++) begin
      @(negedge clk) rx_err = 5'b1 << b;
      @(negedge clk) rx_err = '0;
      rd_chk("R6 rxstat latched", 12'h204, RX_IDLE | (32'h2 << b));
      rd_chk("R9 rxstat rearmed", 12'h204, RX_IDLE);
    end
    for (int l = 0; l < NUM_LANES; l++) begin
      @(negedge clk) begin frame_err = 1 << l; descr_err = 1 << (NUM_LANES-1-l); end
      @(negedge clk) begin frame_err = '0; descr_err = '0; end
      rd_chk("R6 frmerr latched", 12'h224, 32'h1 << l);
      rd_chk("R6 dscerr latched", 12'h228, 32'h1 << (NUM_LANES-1-l));
      rd_chk("R9 frmerr rearmed", 12'h224, 32'h0);
      rd_chk("R9 dscerr rearmed", 12'h228, 32'h0);
    end

    // R7 latch-low
    @(negedge clk) rx_aligned = 0;
    @(negedge clk) rx_aligned = 1;
    rd_chk("R7 aligned lost", 12'h204, RX_IDLE & ~32'h1);
    rd_chk("R9 aligned rearmed", 12'h204, RX_IDLE);
    for (int l = 0; l < NUM_LANES; l++) begin
      @(negedge clk) begin word_sync = ~(12'h1 << l); synced = ~(12'h1 << l); end
      @(negedge clk) begin word_sync = '1; synced = '1; end
      rd_chk("R7 word sync lost", 12'h204, RX_IDLE & ~(32'h100 << l));
      rd_chk("R7 synced lost", 12'h210, 32'h0000_0FFF & ~(32'h1 << l));
      rd_chk("R9 word sync rearmed", 12'h204, RX_IDLE);
      rd_chk("R9 synced rearmed", 12'h210, 32'h0000_0FFF);
    end

    // R9 event present in the read cycle stays latched
    @(negedge clk) frame_err = 12'h008;
    rd(12'h224, d);
    frame_err = '0;
    chk("R9 first read", d, 32'h8);
    rd_chk("R9 read-cycle event kept", 12'h224, 32'h8);
    rd_chk("R9 then clear", 12'h224, 32'h0);
    @(negedge clk) synced = 12'hFF7;
    rd(12'h210, d);
    synced = '1;
    chk("R9 low first read", d, 32'hFF7);
    rd_chk("R9 low read-cycle kept", 12'h210, 32'hFF7);
    rd_chk("R9 low then set", 12'h210, 32'hFFF);

    // R10/R11 snapshot
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      for (int i = 0; i < NUM_CNT; i++) cnt_bus[i*CNT_W +: CNT_W] = cval(i, r);
      wr(12'h2B0, 32'h1);
      for (int i = 0; i < NUM_CNT; i++) cnt_bus[i*CNT_W +: CNT_W] = ~cval(i, r);
      for (int i = 0; i < NUM_CNT; i++)
        rd_chk("R10 snapshot value", 12'h300 + 12'(4*i), cval(i, r));
      wr(12'h2B0, 32'h0);
      for (int i = 0; i < NUM_CNT; i++)
        rd_chk("R11 hold stable", 12'h300 + 12'(4*i), cval(i, r));
      rd_chk("R10 tick reads zero", 12'h2B0, 32'h0);
    end

    // R12 unmapped, unaligned, read-only
    rd_chk("R12 unmapped 0x01C", 12'h01C, 32'h0);
    rd_chk("R12 unmapped 0x2AC", 12'h2AC, 32'h0);
    rd_chk("R12 beyond counters", 12'h300 + 12'(4*NUM_CNT), 32'h0);
    rd_chk("R12 unaligned", 12'h301, 32'h0);
    rd_chk("R12 top page", 12'hFFC, 32'h0);
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R1 version after write", 12'h000, 32'h0000_0205);
    wr(12'h200, 32'hFFFF_FFFF);
    rd_chk("R12 status write ignored", 12'h200, 32'h0);
    wr(12'h300, 32'hFFFF_FFFF);
    rd_chk("R12 hold write ignored", 12'h300, cval(0, 3));
    wr(12'h1F0, 32'hFFFF_FFFF);
    rd_chk("R12 config untouched", 12'h018, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule